// File: doc/BRIEF.md
# MSI Event Queue Controller

This block turns message-signalled interrupt writes into interrupt events for several queues. The doorbell port carries writes that have already landed in the dedicated MSI window. The offset of each write picks a queue, and a write the block accepts advances that queue's tail index by one. Each queue keeps a 6-bit head index and a 6-bit tail index that wrap modulo 64. The number of pending events is the tail minus the head, modulo 64. Software drains a queue by writing a new head value through the register port.

Each queue drives its own level interrupt. The interrupt is high while the queue holds pending events and all of its enables are set. In legacy mode the interrupt also needs that queue's bit in a global enable register. Any asserted legacy INTx status bit holds every MSI interrupt low, because then the MSI path is not the interrupt source. A doorbell that finds its queue holding 63 events is discarded, and a sticky overflow bit is set for that queue.

Top module: `msi_eq_ctrl`

## Requirements
- R1: After reset, every head, tail, control, global enable and overflow register reads 0, and `irq` is 0.
- R2: A doorbell is accepted when all of the following hold: the offset equals 4×n (n < 6), the data equals n, and queue n has its enable (control bit 0) set. An accepted doorbell raises the tail of queue n by one on the next clock edge. No other tail changes.
- R3: A doorbell is dropped without changing any tail in each of these cases: the queue is disabled, the offset is not a multiple of 4, the offset is 0x18 or above, or the data differs from the queue number.
- R4: Head and tail wrap modulo 64. A doorbell at tail 63 makes the tail 0, and the pending count is (tail − head) mod 64.
- R5: A doorbell to an enabled queue that already holds 63 pending events leaves the tail unchanged. It sets bit n of the sticky overflow register at 0x240. Writing 1 to bit n of that register clears the bit.
- R6: `irq[n]` is high when the pending count of queue n is nonzero and control bits 0, 1 and 11 are all set. `irq[n]` goes low in the cycle after a head write makes the head equal the tail.
- R7: While `legacy_mode` is 1, `irq[n]` also needs bit n of the global enable register at 0x208.
- R8: While any bit of `intx_status` is 1, every bit of `irq` is 0. This gating is combinational.
- R9: The control register of queue n sits at 0x210+4n and reads back only bits 0, 1 and 11. The head of queue n sits at 0x250+8n and is read/write in its low 6 bits. A read returns its data on `reg_rdata` with `reg_rvalid` high one cycle after the request.
- R10: The tail of queue n, at 0x254+8n, is read-only and reads back in its low 6 bits. A write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| db_valid | input | 1 | Doorbell write strobe |
| db_offset | input | 12 | Byte offset of the write within the MSI window |
| db_data | input | 32 | Data carried by the doorbell write |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| reg_rvalid | output | 1 | Marks valid read data |
| legacy_mode | input | 1 | Requires the global enable bits for interrupts |
| intx_status | input | 4 | Legacy INTx status; any set bit masks MSI interrupts |
| irq | output | 6 | Per-queue interrupt lines |

## Verification
A wrong tail or head shows on the next register read of that queue. If the tail is off by one or fails to wrap, the readback is wrong on the first read after the faulty doorbell. The fault is also visible at once on `irq[n]`: a queue that should be drained still shows a pending interrupt in the cycle after the head write, and a queue with events shows none. Stuck control or overflow state also appears at the ports. A mis-stored enable bit changes `irq` in the cycle after the control write. A lost overflow bit shows on the overflow register read right after the 64th doorbell.

// File: rtl/msi_eq_pkg.sv
`timescale 1ns/1ps
package msi_eq_pkg;
  // Register byte offsets
  localparam int unsigned GEN_EN_OFS  = 32'h208;
  localparam int unsigned CTL_BASE    = 32'h210;
  localparam int unsigned OVF_OFS     = 32'h240;
  localparam int unsigned PTR_BASE    = 32'h250;
  localparam int unsigned CTL_STRIDE  = 4;
  localparam int unsigned PTR_STRIDE  = 8;
  localparam int unsigned TAIL_DELTA  = 4;
  localparam int unsigned DB_STRIDE   = 4;

  // Control bit positions
  localparam int unsigned CTL_QEN_BIT = 0;
  localparam int unsigned CTL_IOE_BIT = 1;
  localparam int unsigned CTL_IEN_BIT = 11;

  typedef struct packed {
    logic int_en;
    logic int_on_evt;
    logic q_en;
  } qctl_t;
endpackage

// File: rtl/msi_eq_doorbell.sv
`timescale 1ns/1ps
module msi_eq_doorbell
  import msi_eq_pkg::*;
#(
  parameter int NUM_Q = 6,
  parameter int DB_AW = 12,
  parameter int DW    = 32
) (
  input  logic             db_valid,
  input  logic [DB_AW-1:0] db_offset,
  input  logic [DW-1:0]    db_data,
  output logic [NUM_Q-1:0] db_hit
);
  // One comparator pair per queue: offset slot and data tag must both match.
  for (genvar n = 0; n < NUM_Q; n++) begin : g_slot
    localparam logic [DB_AW-1:0] SLOT_OFS = DB_AW'(DB_STRIDE * n);
    localparam logic [DW-1:0]    SLOT_TAG = DW'(n);
    assign db_hit[n] = db_valid & (db_offset == SLOT_OFS) & (db_data == SLOT_TAG);
  end
endmodule

// File: rtl/msi_eq_queue.sv
`timescale 1ns/1ps
module msi_eq_queue
  import msi_eq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_hit,
  input  logic             ctl_we,
  input  qctl_t            ctl_wval,
  input  logic             head_we,
  input  logic [IDX_W-1:0] head_wval,
  input  logic             ovf_clr,
  input  logic             gen_en,
  input  logic             legacy_mode,
  input  logic             intx_quiet,
  output qctl_t            ctl,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             ovf,
  output logic             irq
);
  qctl_t            ctl_q;
  logic [IDX_W-1:0] head_q, tail_q, tail_d, pending;
  logic             ovf_q, ovf_d, full, take, spill, tail_en, ovf_en;

  // next-state
  always_comb begin
    pending = tail_q - head_q;
    full    = &pending;
    take    = db_hit & ctl_q.q_en & ~full;
    spill   = db_hit & ctl_q.q_en & full;
    tail_en = take;
    tail_d  = tail_q + IDX_W'(1);
    ovf_en  = spill | ovf_clr;
    ovf_d   = spill;              // a new overflow wins over a clear
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (ctl_we)  ctl_q  <= ctl_wval;
      if (head_we) head_q <= head_wval;
      if (tail_en) tail_q <= tail_d;
      if (ovf_en)  ovf_q  <= ovf_d;
    end
  end

  assign irq  = (|pending) & ctl_q.q_en & ctl_q.int_on_evt & ctl_q.int_en
              & (~legacy_mode | gen_en) & intx_quiet;
  assign ctl  = ctl_q;
  assign head = head_q;
  assign tail = tail_q;
  assign ovf  = ovf_q;
endmodule

// File: rtl/msi_eq_regs.sv
`timescale 1ns/1ps
module msi_eq_regs
  import msi_eq_pkg::*;
#(
  parameter int NUM_Q = 6,
  parameter int RA_W  = 12,
  parameter int DW    = 32,
  parameter int IDX_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_valid,
  input  logic                        reg_write,
  input  logic [RA_W-1:0]             reg_addr,
  input  logic [DW-1:0]               reg_wdata,
  input  qctl_t [NUM_Q-1:0]           ctl_rd,
  input  logic [NUM_Q-1:0][IDX_W-1:0] head_rd,
  input  logic [NUM_Q-1:0][IDX_W-1:0] tail_rd,
  input  logic [NUM_Q-1:0]            ovf_rd,
  output logic [NUM_Q-1:0]            ctl_we,
  output qctl_t                       ctl_wval,
  output logic [NUM_Q-1:0]            head_we,
  output logic [IDX_W-1:0]            head_wval,
  output logic [NUM_Q-1:0]            ovf_clr,
  output logic [NUM_Q-1:0]            gen_en,
  output logic [DW-1:0]               reg_rdata,
  output logic                        reg_rvalid
);
  localparam logic [RA_W-1:0] A_GEN = RA_W'(GEN_EN_OFS);
  localparam logic [RA_W-1:0] A_OVF = RA_W'(OVF_OFS);

  logic             wr_stb, rd_stb, gen_hit, ovf_hit;
  logic [NUM_Q-1:0] ctl_hit, head_hit, tail_hit;
  logic [NUM_Q-1:0] gen_q;
  logic [DW-1:0]    rdata_d, rdata_q;
  logic             rvld_q;
  logic             unused_wbits;

  assign wr_stb  = reg_valid & reg_write;
  assign rd_stb  = reg_valid & ~reg_write;
  assign gen_hit = (reg_addr == A_GEN);
  assign ovf_hit = (reg_addr == A_OVF);

  for (genvar n = 0; n < NUM_Q; n++) begin : g_dec
    localparam logic [RA_W-1:0] A_CTL  = RA_W'(CTL_BASE + CTL_STRIDE * n);
    localparam logic [RA_W-1:0] A_HEAD = RA_W'(PTR_BASE + PTR_STRIDE * n);
    localparam logic [RA_W-1:0] A_TAIL = RA_W'(PTR_BASE + PTR_STRIDE * n + TAIL_DELTA);
    assign ctl_hit[n]  = (reg_addr == A_CTL);
    assign head_hit[n] = (reg_addr == A_HEAD);
    assign tail_hit[n] = (reg_addr == A_TAIL);
  end

  // Write strobes; the tail decode feeds reads only.
  assign ctl_we    = {NUM_Q{wr_stb}} & ctl_hit;
  assign head_we   = {NUM_Q{wr_stb}} & head_hit;
  assign ovf_clr   = {NUM_Q{wr_stb & ovf_hit}} & reg_wdata[NUM_Q-1:0];
  assign ctl_wval  = '{int_en:     reg_wdata[CTL_IEN_BIT],
                       int_on_evt: reg_wdata[CTL_IOE_BIT],
                       q_en:       reg_wdata[CTL_QEN_BIT]};
  assign head_wval = reg_wdata[IDX_W-1:0];
  assign unused_wbits = ^reg_wdata;

  // read data next-state
  always_comb begin
    rdata_d = '0;
    if (gen_hit) rdata_d = rdata_d | DW'(gen_q);
    if (ovf_hit) rdata_d = rdata_d | DW'(ovf_rd);
    for (int n = 0; n < NUM_Q; n++) begin
      if (ctl_hit[n]) begin
        rdata_d[CTL_QEN_BIT] = rdata_d[CTL_QEN_BIT] | ctl_rd[n].q_en;
        rdata_d[CTL_IOE_BIT] = rdata_d[CTL_IOE_BIT] | ctl_rd[n].int_on_evt;
        rdata_d[CTL_IEN_BIT] = rdata_d[CTL_IEN_BIT] | ctl_rd[n].int_en;
      end
      if (head_hit[n]) rdata_d = rdata_d | DW'(head_rd[n]);
      if (tail_hit[n]) rdata_d = rdata_d | DW'(tail_rd[n]);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= '0;
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rvld_q <= rd_stb;
      if (wr_stb & gen_hit) gen_q   <= reg_wdata[NUM_Q-1:0];
      if (rd_stb)           rdata_q <= rdata_d;
    end
  end

  assign gen_en     = gen_q;
  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvld_q;
endmodule

// File: rtl/msi_eq_ctrl.sv
`timescale 1ns/1ps
module msi_eq_ctrl
  import msi_eq_pkg::*;
#(
  parameter int NUM_Q  = 6,
  parameter int IDX_W  = 6,
  parameter int RA_W   = 12,
  parameter int DB_AW  = 12,
  parameter int DW     = 32,
  parameter int INTX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_valid,
  input  logic [DB_AW-1:0]  db_offset,
  input  logic [DW-1:0]     db_data,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_rvalid,
  input  logic              legacy_mode,
  input  logic [INTX_W-1:0] intx_status,
  output logic [NUM_Q-1:0]  irq
);
  logic [NUM_Q-1:0]            db_hit, ctl_we, head_we, ovf_clr, gen_en, ovf_vec;
  qctl_t                       ctl_wval;
  qctl_t [NUM_Q-1:0]           ctl_vec;
  logic [IDX_W-1:0]            head_wval;
  logic [NUM_Q-1:0][IDX_W-1:0] head_vec, tail_vec;
  logic                        intx_quiet;

  assign intx_quiet = ~|intx_status;

  msi_eq_doorbell #(.NUM_Q(NUM_Q), .DB_AW(DB_AW), .DW(DW)) u_doorbell (
    .db_valid (db_valid),
    .db_offset(db_offset),
    .db_data  (db_data),
    .db_hit   (db_hit)
  );

  msi_eq_regs #(.NUM_Q(NUM_Q), .RA_W(RA_W), .DW(DW), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ctl_rd    (ctl_vec),
    .head_rd   (head_vec),
    .tail_rd   (tail_vec),
    .ovf_rd    (ovf_vec),
    .ctl_we    (ctl_we),
    .ctl_wval  (ctl_wval),
    .head_we   (head_we),
    .head_wval (head_wval),
    .ovf_clr   (ovf_clr),
    .gen_en    (gen_en),
    .reg_rdata (reg_rdata),
    .reg_rvalid(reg_rvalid)
  );

  for (genvar n = 0; n < NUM_Q; n++) begin : g_queue
    msi_eq_queue #(.IDX_W(IDX_W)) u_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .db_hit     (db_hit[n]),
      .ctl_we     (ctl_we[n]),
      .ctl_wval   (ctl_wval),
      .head_we    (head_we[n]),
      .head_wval  (head_wval),
      .ovf_clr    (ovf_clr[n]),
      .gen_en     (gen_en[n]),
      .legacy_mode(legacy_mode),
      .intx_quiet (intx_quiet),
      .ctl        (ctl_vec[n]),
      .head       (head_vec[n]),
      .tail       (tail_vec[n]),
      .ovf        (ovf_vec[n]),
      .irq        (irq[n])
    );
  end
endmodule

// File: rtl/msi_eq_ctrl_sva.sv
`timescale 1ns/1ps
module msi_eq_ctrl_sva #(
  parameter int NUM_Q  = 6,
  parameter int IDX_W  = 6,
  parameter int INTX_W = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        db_valid,
  input logic                        reg_valid,
  input logic                        reg_write,
  input logic                        reg_rvalid,
  input logic [INTX_W-1:0]           intx_status,
  input logic [NUM_Q-1:0]            irq,
  input logic [NUM_Q-1:0][IDX_W-1:0] head_vec,
  input logic [NUM_Q-1:0][IDX_W-1:0] tail_vec,
  input logic [NUM_Q-1:0]            ovf_vec
);
  p_intx_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|intx_status) |-> (irq == '0));

  p_idle_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !db_valid |=> $stable(tail_vec));

  p_read_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write) |=> reg_rvalid);

  for (genvar n = 0; n < NUM_Q; n++) begin : g_q
    p_tail_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      db_valid |=> (tail_vec[n] == $past(tail_vec[n]) ||
                    tail_vec[n] == IDX_W'($past(tail_vec[n]) + IDX_W'(1))));

    p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (IDX_W'(tail_vec[n] - head_vec[n]) == {IDX_W{1'b1}}) |=> (tail_vec[n] == $past(tail_vec[n])));

    p_ovf_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_vec[n]) |-> (IDX_W'($past(tail_vec[n]) - $past(head_vec[n])) == {IDX_W{1'b1}}));

    p_irq_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[n] |-> (tail_vec[n] != head_vec[n]));
  end
endmodule

bind msi_eq_ctrl msi_eq_ctrl_sva #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .INTX_W(INTX_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .db_valid   (db_valid),
  .reg_valid  (reg_valid),
  .reg_write  (reg_write),
  .reg_rvalid (reg_rvalid),
  .intx_status(intx_status),
  .irq        (irq),
  .head_vec   (head_vec),
  .tail_vec   (tail_vec),
  .ovf_vec    (ovf_vec)
);

// File: tb/msi_eq_ctrl_bench.sv
`timescale 1ns/1ps
module msi_eq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        db_valid;
  logic [11:0] db_offset;
  logic [31:0] db_data;
  logic        reg_valid, reg_write;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        legacy_mode;
  logic [3:0]  intx_status;
  logic [5:0]  irq;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  msi_eq_ctrl u_msi_eq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .db_valid(db_valid), .db_offset(db_offset), .db_data(db_data),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .legacy_mode(legacy_mode), .intx_status(intx_status), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Driver tasks: entered and left at a falling edge.
  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic db_raw(input logic [11:0] ofs, input logic [31:0] d);
    db_valid = 1'b1; db_offset = ofs; db_data = d;
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic ring(input int q);
    db_raw(12'(4 * q), 32'(q));
  endtask

  // Monitor: pops the scoreboard whenever read data is presented.
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R9: unexpected read data actual %h expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, reg_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; db_valid = 1'b0; db_offset = '0; db_data = '0;
    reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0;
    legacy_mode = 1'b0; intx_status = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    reg_rd(12'h210, 32'h0, "R1 ctrl0");
    reg_rd(12'h250, 32'h0, "R1 head0");
    reg_rd(12'h254, 32'h0, "R1 tail0");
    reg_rd(12'h208, 32'h0, "R1 global enable");
    reg_rd(12'h240, 32'h0, "R1 overflow");

    // R3 disabled queue drops doorbells
    ring(2);
    ring(0);
    reg_rd(12'h264, 32'h0, "R3 tail2 disabled");
    reg_rd(12'h254, 32'h0, "R3 tail0 disabled");

    // R9 control readback masks to bits 0,1,11
    reg_wr(12'h218, 32'hFFFF_FFFF);
    reg_rd(12'h218, 32'h0000_0803, "R9 ctrl2 readback");

    // R2 accepted doorbells
    ring(2); ring(2); ring(2);
    chk("R6 irq after events", 32'(irq), 32'h04);
    reg_rd(12'h264, 32'h3, "R2 tail2 after three");
    reg_rd(12'h25C, 32'h0, "R2 tail1 untouched");

    // R3 malformed doorbells
    db_raw(12'h009, 32'h2);
    db_raw(12'h008, 32'h5);
    db_raw(12'h018, 32'h6);
    db_raw(12'h01C, 32'h7);
    reg_rd(12'h264, 32'h3, "R3 tail2 after malformed");

    // R6 head write drains
    reg_wr(12'h260, 32'h2);
    chk("R6 irq one pending", 32'(irq), 32'h04);
    reg_wr(12'h260, 32'h3);
    chk("R6 irq drop after drain", 32'(irq), 32'h00);
    reg_rd(12'h260, 32'h3, "R9 head2 readback");

    // R10 tail write ignored
    reg_wr(12'h264, 32'h15);
    reg_rd(12'h264, 32'h3, "R10 tail2 after write");

    // R6 each enable gates the line
    reg_wr(12'h218, 32'h0000_0003);
    ring(2);
    chk("R6 irq without bit11", 32'(irq), 32'h00);
    reg_wr(12'h218, 32'h0000_0803);
    chk("R6 irq all enables", 32'(irq), 32'h04);
    reg_wr(12'h218, 32'h0000_0801);
    chk("R6 irq without bit1", 32'(irq), 32'h00);
    reg_wr(12'h218, 32'h0000_0803);
    reg_rd(12'h264, 32'h4, "R2 tail2 after gated event");

    // R8 INTx masks MSI interrupts
    intx_status = 4'b0010;
    #1 chk("R8 irq masked by INTx", 32'(irq), 32'h00);
    @(negedge clk);
    intx_status = 4'b0000;
    #1 chk("R8 irq back after INTx", 32'(irq), 32'h04);
    @(negedge clk);

    // R7 legacy mode needs global enable
    legacy_mode = 1'b1;
    #1 chk("R7 irq legacy no global", 32'(irq), 32'h00);
    @(negedge clk);
    reg_wr(12'h208, 32'h04);
    chk("R7 irq legacy with global", 32'(irq), 32'h04);
    reg_rd(12'h208, 32'h04, "R7 global enable readback");
    legacy_mode = 1'b0;

    // R5 full queue and overflow
    reg_wr(12'h224, 32'h0000_0803);
    for (int i = 0; i < 63; i++) ring(5);
    reg_rd(12'h27C, 32'd63, "R5 tail5 at 63 pending");
    chk("R6 irq two queues", 32'(irq), 32'h24);
    ring(5);
    reg_rd(12'h27C, 32'd63, "R5 tail5 after discard");
    reg_rd(12'h240, 32'h20, "R5 overflow set");
    reg_wr(12'h240, 32'h04);
    reg_rd(12'h240, 32'h20, "R5 overflow other bit clear");
    reg_wr(12'h240, 32'h20);
    reg_rd(12'h240, 32'h00, "R5 overflow cleared");

    // R4 wrap
    reg_wr(12'h278, 32'd63);
    chk("R6 irq q5 drained", 32'(irq), 32'h04);
    ring(5);
    reg_rd(12'h27C, 32'h0, "R4 tail5 wrapped");
    chk("R4 irq after wrap", 32'(irq), 32'h24);

    repeat (3) @(negedge clk);
    chk("R9 all reads answered", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule